// File: doc/BRIEF.md
# Banked GPIO Controller with Indirect Data Window

This block is a general-purpose I/O controller for 22 pins, split into three banks of 8, 6 and 8 pins. A byte-wide synchronous configuration bus reaches it. Each pin has its own function register. That register selects the pin's direction, its polarity, and whether the pin carries plain GPIO data or a signal from an alternate internal peripheral. The alternate peripherals lie outside the block. Each one appears as a per-pin `alt_out` input and a per-pin `alt_in` output.

Pin data has no address of its own. Software first sets a global control register. That register switches on an index/data window and places the window at one of four address pairs. Software then writes a bank number to the window index address and reads or writes the window data address. While the window is on, its two addresses shadow the function registers that normally live there. A separate activation register gates every output enable, so a cleared activation bit leaves all pins high-impedance.

Each host access passes through an access-class decoder. The decoder sorts the address into one of six classes: `ACC_NONE`, `ACC_CTL`, `ACC_ACT`, `ACC_FUNC`, `ACC_WIDX` and `ACC_WDAT`. A `unique case` on that class then drives the register updates, the bank write strobes and the read data. The class is recomputed on every cycle from the address and the current window settings, so no class depends on an earlier one.

Top module: `gpio_window_ctrl`

## Requirements
- R1: After reset, every function register reads 0x01 (input, non-inverted, normal function). The control register, the activation register, the window index and `cfg_rdata` read 0. All output latches are 0 and every `pin_oe` bit is 0.
- R2: Function registers sit at 0xE0+n for pins 10–17, at 0xE8+n for pins 20–25 and at 0xF5+n for pins 30–37. Bit 0 is direction (1 = input), bit 1 is polarity (1 = inverted) and bit 3 selects the alternate function (1 = alternate). All other bits read 0.
- R3: Register 0x30 stores only bit 0, the activation bit. While that bit is 0, every `pin_oe` bit is 0.
- R4: A pin drives (`pin_oe` = 1) when the block is active and the pin's direction bit is 0. In normal function, `pin_out` equals the pin's output latch XOR its polarity bit.
- R5: In alternate function, `pin_out` equals `alt_out` XOR polarity. `alt_in` always equals the synchronized pin level XOR polarity.
- R6: Register 0x03 stores bit 7 (window enable) and bits 1–0 (window placement). Bits 6–2 read 0.
- R7: Placement values 0, 1, 2 and 3 put the window index/data pair at 0xE0/0xE1, 0xE2/0xE3, 0xE4/0xE5 and 0xEA/0xEB. The index address reads back the stored index.
- R8: While the window is enabled, reads and writes at its two addresses reach the window and leave the function registers at those addresses unchanged. Once the window is disabled, those addresses reach the function registers again.
- R9: Window index 0x01, 0x02 and 0x03 select the data of the first, second and third bank (bit k = pin offset k). A data read returns the synchronized pin level XOR polarity for input pins, and the output latch for output pins. A data write loads that bank's output latches.
- R10: Through index 0x02, data bits 7–6 always read 0.
- R11: With any window index other than 0x01–0x03, a data read returns 0 and a data write changes no latch.
- R12: Read data is registered. It appears on `cfg_rdata` after the clock edge that samples `cfg_rd`, and it holds while `cfg_rd` is low. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_addr | input | 8 | Configuration bus address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_wr | input | 1 | Write strobe, one access per cycle |
| cfg_rd | input | 1 | Read strobe |
| cfg_rdata | output | 8 | Registered read data |
| pin_in | input | 22 | Pad input levels (bits 7:0 bank 1, 13:8 bank 2, 21:14 bank 3) |
| pin_out | output | 22 | Pad output values |
| pin_oe | output | 22 | Pad output enables |
| alt_out | input | 22 | Output signals from the alternate peripherals |
| alt_in | output | 22 | Polarity-corrected pin levels to the alternate peripherals |

## Verification
The shadowing rule is the hardest behaviour to reach from the ports. A window write at an overlaid address must leave the function register underneath intact, and that is visible only after the window is switched off again. The stimulus places the window on live function registers, first at 0xE0/0xE1 and then at 0xEA/0xEB over the middle bank. It writes through the window there, disables the window and reads the same addresses back as function registers. A wrong index value reaches the latches only through a side effect, so the bench watches `pin_out` on an inverted output pin after the stray write.

// File: rtl/gpw_pkg.sv
package gpw_pkg;

    localparam int NUM_BANKS = 3;
    localparam int NUM_PINS  = 22;
    localparam int DATA_W    = 8;
    localparam int OFF_W     = 3;

    localparam logic [7:0] ADDR_CTL = 8'h03;
    localparam logic [7:0] ADDR_ACT = 8'h30;

    // access class chosen by the address decoder
    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_CTL,
        ACC_ACT,
        ACC_FUNC,
        ACC_WIDX,
        ACC_WDAT
    } acc_e;

    typedef struct packed {
        logic alt;   // alternate function select
        logic inv;   // polarity invert
        logic dir;   // 1 = input
    } pin_fn_t;

    function automatic int bank_width(input int b);
        return (b == 1) ? 6 : 8;
    endfunction

    function automatic int bank_lsb(input int b);
        case (b)
            0:       return 0;
            1:       return 8;
            default: return 14;
        endcase
    endfunction

    function automatic logic [7:0] bank_fbase(input int b);
        case (b)
            0:       return 8'hE0;
            1:       return 8'hE8;
            default: return 8'hF5;
        endcase
    endfunction

endpackage

// File: rtl/gpw_decode.sv
module gpw_decode
    import gpw_pkg::*;
(
    input  logic [7:0]       addr,
    input  logic             win_en,
    input  logic [1:0]       win_sel,
    output acc_e             acc,
    output logic [1:0]       bank,
    output logic [OFF_W-1:0] off
);

    logic [7:0] win_base;
    logic [7:0] rel;

    always_comb begin
        unique case (win_sel)
            2'd0: win_base = 8'hE0;
            2'd1: win_base = 8'hE2;
            2'd2: win_base = 8'hE4;
            2'd3: win_base = 8'hEA;
        endcase
    end

    always_comb begin
        acc  = ACC_NONE;
        bank = '0;
        off  = '0;
        rel  = '0;
        if (addr == ADDR_CTL) begin
            acc = ACC_CTL;
        end else if (addr == ADDR_ACT) begin
            acc = ACC_ACT;
        end else if (win_en && addr == win_base) begin
            acc = ACC_WIDX;
        end else if (win_en && addr == win_base + 8'd1) begin
            acc = ACC_WDAT;
        end else begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                rel = addr - bank_fbase(b);
                if (rel < 8'(bank_width(b))) begin
                    acc  = ACC_FUNC;
                    bank = 2'(b);
                    off  = rel[OFF_W-1:0];
                end
            end
        end
    end

endmodule

// File: rtl/gpw_bank.sv
module gpw_bank
    import gpw_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              fn_we,
    input  logic [OFF_W-1:0]  fn_off,
    input  logic              data_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [WIDTH-1:0]  pin_in,
    input  logic [WIDTH-1:0]  alt_out,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe,
    output logic [WIDTH-1:0]  alt_in,
    output logic [DATA_W-1:0] fn_rdata,
    output logic [DATA_W-1:0] data_rdata
);

    pin_fn_t          fn_q   [WIDTH];
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] sync_q [SYNC_STAGES];
    logic [WIDTH-1:0] pin_lvl;
    logic [WIDTH-1:0] rd_bits;

    // function registers and output latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WIDTH; i++) begin
                fn_q[i] <= '{alt: 1'b0, inv: 1'b0, dir: 1'b1};
            end
            latch_q <= '0;
        end else begin
            if (fn_we) begin
                for (int i = 0; i < WIDTH; i++) begin
                    if (fn_off == OFF_W'(i)) begin
                        fn_q[i] <= '{alt: wdata[3], inv: wdata[1], dir: wdata[0]};
                    end
                end
            end
            if (data_we) begin
                latch_q <= wdata[WIDTH-1:0];
            end
        end
    end

    // input synchronizer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SYNC_STAGES; s++) begin
                sync_q[s] <= '0;
            end
        end else begin
            sync_q[0] <= pin_in;
            for (int s = 1; s < SYNC_STAGES; s++) begin
                sync_q[s] <= sync_q[s-1];
            end
        end
    end

    assign pin_lvl = sync_q[SYNC_STAGES-1];

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        assign pin_oe[i]  = active & ~fn_q[i].dir;
        assign pin_out[i] = (fn_q[i].alt ? alt_out[i] : latch_q[i]) ^ fn_q[i].inv;
        assign alt_in[i]  = pin_lvl[i] ^ fn_q[i].inv;
        assign rd_bits[i] = fn_q[i].dir ? (pin_lvl[i] ^ fn_q[i].inv) : latch_q[i];
    end

    always_comb begin
        data_rdata             = '0;
        data_rdata[WIDTH-1:0]  = rd_bits;
    end

    always_comb begin
        fn_rdata = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (fn_off == OFF_W'(i)) begin
                fn_rdata = {4'b0000, fn_q[i].alt, 1'b0, fn_q[i].inv, fn_q[i].dir};
            end
        end
    end

endmodule

// File: rtl/gpio_window_ctrl.sv
module gpio_window_ctrl
    import gpw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [7:0]          cfg_addr,
    input  logic [DATA_W-1:0]   cfg_wdata,
    input  logic                cfg_wr,
    input  logic                cfg_rd,
    output logic [DATA_W-1:0]   cfg_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    input  logic [NUM_PINS-1:0] alt_out,
    output logic [NUM_PINS-1:0] alt_in
);

    logic              win_en_q;
    logic [1:0]        win_sel_q;
    logic              act_q;
    logic [DATA_W-1:0] widx_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rd_next;

    acc_e              acc;
    logic [1:0]        acc_bank;
    logic [OFF_W-1:0]  acc_off;

    logic                 widx_ok;
    logic [1:0]           widx_bank;
    logic [NUM_BANKS-1:0] fn_we;
    logic [NUM_BANKS-1:0] data_we;
    logic [DATA_W-1:0]    bank_fn_rd  [NUM_BANKS];
    logic [DATA_W-1:0]    bank_dat_rd [NUM_BANKS];

    gpw_decode u_decode (
        .addr    (cfg_addr),
        .win_en  (win_en_q),
        .win_sel (win_sel_q),
        .acc     (acc),
        .bank    (acc_bank),
        .off     (acc_off)
    );

    assign widx_ok   = (widx_q[7:2] == '0) && (widx_q[1:0] != 2'd0);
    assign widx_bank = widx_q[1:0] - 2'd1;

    // bank write strobes
    always_comb begin
        fn_we   = '0;
        data_we = '0;
        if (cfg_wr) begin
            unique case (acc)
                ACC_FUNC: fn_we[acc_bank] = 1'b1;
                ACC_WDAT: if (widx_ok) data_we[widx_bank] = 1'b1;
                default:  ;
            endcase
        end
    end

    // read data selection
    always_comb begin
        unique case (acc)
            ACC_CTL:  rd_next = {win_en_q, 5'b00000, win_sel_q};
            ACC_ACT:  rd_next = {7'b0000000, act_q};
            ACC_FUNC: rd_next = bank_fn_rd[acc_bank];
            ACC_WIDX: rd_next = widx_q;
            ACC_WDAT: rd_next = widx_ok ? bank_dat_rd[widx_bank] : '0;
            default:  rd_next = '0;
        endcase
    end

    // global registers and read register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_en_q  <= 1'b0;
            win_sel_q <= 2'd0;
            act_q     <= 1'b0;
            widx_q    <= '0;
            rdata_q   <= '0;
        end else begin
            if (cfg_wr) begin
                unique case (acc)
                    ACC_CTL: begin
                        win_en_q  <= cfg_wdata[7];
                        win_sel_q <= cfg_wdata[1:0];
                    end
                    ACC_ACT:  act_q  <= cfg_wdata[0];
                    ACC_WIDX: widx_q <= cfg_wdata;
                    default:  ;
                endcase
            end
            if (cfg_rd) begin
                rdata_q <= rd_next;
            end
        end
    end

    assign cfg_rdata = rdata_q;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int W = bank_width(b);
        localparam int L = bank_lsb(b);

        gpw_bank #(
            .WIDTH       (W),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .active     (act_q),
            .fn_we      (fn_we[b]),
            .fn_off     (acc_off),
            .data_we    (data_we[b]),
            .wdata      (cfg_wdata),
            .pin_in     (pin_in[L +: W]),
            .alt_out    (alt_out[L +: W]),
            .pin_out    (pin_out[L +: W]),
            .pin_oe     (pin_oe[L +: W]),
            .alt_in     (alt_in[L +: W]),
            .fn_rdata   (bank_fn_rd[b]),
            .data_rdata (bank_dat_rd[b])
        );
    end

endmodule

// File: rtl/gpw_checker.sv
module gpw_checker
    import gpw_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [7:0]          cfg_addr,
    input logic [DATA_W-1:0]   cfg_wdata,
    input logic                cfg_wr,
    input logic                cfg_rd,
    input logic [DATA_W-1:0]   cfg_rdata,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic                act_q,
    input logic                win_en_q,
    input logic [1:0]          win_sel_q,
    input logic [DATA_W-1:0]   widx_q
);

    logic [7:0] exp_idx_addr;
    logic [7:0] exp_dat_addr;

    always_comb begin
        case (win_sel_q)
            2'd0:    exp_idx_addr = 8'hE0;
            2'd1:    exp_idx_addr = 8'hE2;
            2'd2:    exp_idx_addr = 8'hE4;
            default: exp_idx_addr = 8'hEA;
        endcase
        exp_dat_addr = exp_idx_addr + 8'd1;
    end

    AST_HIZ_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !act_q |-> (pin_oe == '0)); // R3

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd |=> $stable(cfg_rdata)); // R12

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && cfg_addr > 8'h30 && cfg_addr < 8'hE0) |=> (cfg_rdata == '0)); // R12

    AST_CTL_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && cfg_addr == ADDR_CTL) |=> (cfg_rdata[6:2] == '0)); // R6

    AST_WIDX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && win_en_q && cfg_addr == exp_idx_addr) |=> (widx_q == $past(cfg_wdata))); // R8

    AST_BAD_INDEX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && !cfg_wr && win_en_q && cfg_addr == exp_dat_addr &&
         (widx_q == 8'd0 || widx_q > 8'd3)) |=> (cfg_rdata == '0)); // R11

    AST_BANK2_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && !cfg_wr && win_en_q && cfg_addr == exp_dat_addr && widx_q == 8'd2)
        |=> (cfg_rdata[7:6] == 2'b00)); // R10

endmodule

bind gpio_window_ctrl gpw_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_wr    (cfg_wr),
    .cfg_rd    (cfg_rd),
    .cfg_rdata (cfg_rdata),
    .pin_oe    (pin_oe),
    .act_q     (act_q),
    .win_en_q  (win_en_q),
    .win_sel_q (win_sel_q),
    .widx_q    (widx_q)
);

// File: tb/tb_gpio_window_ctrl.sv
module tb_gpio_window_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        cfg_wr = 1'b0;
    logic        cfg_rd = 1'b0;
    logic [7:0]  cfg_rdata;
    logic [21:0] pin_in = '0;
    logic [21:0] pin_out;
    logic [21:0] pin_oe;
    logic [21:0] alt_out = '0;
    logic [21:0] alt_in;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_window_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_wr    (cfg_wr),
        .cfg_rd    (cfg_rd),
        .cfg_rdata (cfg_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .alt_out   (alt_out),
        .alt_in    (alt_in)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_addr  = a;
        cfg_wdata = d;
        cfg_wr    = 1'b1;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        cfg_addr = a;
        cfg_rd   = 1'b1;
        @(negedge clk);
        cfg_rd   = 1'b0;
        d        = cfg_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1", "rdata after reset", cfg_rdata, 0);
        chk("R1", "oe after reset", pin_oe, 0);
        rd(8'h03, v); chk("R1", "ctl reset", v, 8'h00);
        rd(8'h30, v); chk("R1", "act reset", v, 8'h00);
        rd(8'hE0, v); chk("R1", "fn pin10 reset", v, 8'h01);
        rd(8'hEB, v); chk("R1", "fn pin23 reset", v, 8'h01);
        rd(8'hFC, v); chk("R1", "fn pin37 reset", v, 8'h01);
    endtask

    task automatic t_func();
        logic [7:0] v;
        wr(8'hED, 8'hFF);
        rd(8'hED, v); chk("R2", "fn pin25 used bits", v, 8'h0B);
        wr(8'hF7, 8'h0A);
        rd(8'hF7, v); chk("R2", "fn pin32", v, 8'h0A);
        rd(8'hF6, v); chk("R2", "fn pin31 untouched", v, 8'h01);
        wr(8'hED, 8'h01);
        wr(8'hF7, 8'h01);
    endtask

    task automatic t_ctl();
        logic [7:0] v;
        wr(8'h03, 8'hFF);
        rd(8'h03, v); chk("R6", "ctl stored bits", v, 8'h83);
        wr(8'h03, 8'h00);
        rd(8'h03, v); chk("R6", "ctl cleared", v, 8'h00);
    endtask

    task automatic t_outputs();
        logic [7:0] v;
        wr(8'h30, 8'h01);
        wr(8'hE0, 8'h00);
        chk("R4", "pin10 oe", pin_oe[0], 1);
        chk("R4", "pin11 input oe", pin_oe[1], 0);
        wr(8'h03, 8'h80);
        wr(8'hE0, 8'h01);
        wr(8'hE1, 8'h01);
        chk("R4", "pin10 out latch", pin_out[0], 1);
        wr(8'h03, 8'h00);
        rd(8'hE0, v); chk("R8", "fn pin10 shadowed", v, 8'h00);
        rd(8'hE1, v); chk("R8", "fn pin11 shadowed", v, 8'h01);
        wr(8'hE0, 8'h02);
        chk("R4", "pin10 out inverted", pin_out[0], 0);
    endtask

    task automatic t_special();
        wr(8'hF5, 8'h08);
        alt_out[14] = 1'b1;
        #1;
        chk("R5", "pin30 oe alt", pin_oe[14], 1);
        chk("R5", "pin30 out alt", pin_out[14], 1);
        wr(8'hF5, 8'h0A);
        chk("R5", "pin30 out alt inv", pin_out[14], 0);
        wr(8'hF5, 8'h0B);
        pin_in[14] = 1'b1;
        settle();
        chk("R5", "alt_in inverted high", alt_in[14], 0);
        pin_in[14] = 1'b0;
        settle();
        chk("R5", "alt_in inverted low", alt_in[14], 1);
        wr(8'hF5, 8'h01);
        alt_out[14] = 1'b0;
    endtask

    task automatic t_pairs();
        logic [7:0] v;
        logic [7:0] ia;
        pin_in[21:14] = 8'hA5;
        settle();
        for (int sel = 0; sel < 4; sel++) begin
            ia = (sel == 3) ? 8'hEA : 8'(8'hE0 + 2 * sel);
            wr(8'h03, 8'(8'h80 | sel));
            wr(ia, 8'h03);
            rd(ia, v);        chk("R7", "index readback", v, 8'h03);
            rd(ia + 8'd1, v); chk("R9", "bank3 inputs via window", v, 8'hA5);
        end
        wr(8'h03, 8'h00);
        rd(8'hE2, v); chk("R8", "fn pin12 after window", v, 8'h01);
    endtask

    task automatic t_overlay();
        logic [7:0] v;
        wr(8'h03, 8'h83);
        wr(8'hEA, 8'h02);
        wr(8'hEB, 8'h3F);
        wr(8'h03, 8'h00);
        rd(8'hEA, v); chk("R8", "fn pin22 shadowed", v, 8'h01);
        rd(8'hEB, v); chk("R8", "fn pin23 shadowed", v, 8'h01);
        wr(8'hE8, 8'h00);
        pin_in[13:8] = 6'b101010;
        settle();
        wr(8'h03, 8'h83);
        rd(8'hEB, v); chk("R10", "bank2 data", v, 8'h2B);
        wr(8'hEB, 8'h3E);
        chk("R9", "pin20 latch cleared", pin_out[8], 0);
        rd(8'hEB, v); chk("R9", "bank2 mixed read", v, 8'h2A);
        wr(8'hEB, 8'hFF);
        chk("R9", "pin20 latch set", pin_out[8], 1);
        rd(8'hEB, v); chk("R10", "bank2 top bits zero", v, 8'h2B);
        wr(8'h03, 8'h00);
    endtask

    task automatic t_bad_index();
        logic [7:0] v;
        pin_in[7:0] = 8'h00;
        settle();
        wr(8'h03, 8'h80);
        wr(8'hE0, 8'h01);
        wr(8'hE1, 8'h00);
        chk("R11", "pin10 inverted zero latch", pin_out[0], 1);
        wr(8'hE0, 8'h00);
        rd(8'hE1, v); chk("R11", "index 0 read", v, 8'h00);
        wr(8'hE1, 8'hFF);
        chk("R11", "index 0 write ignored", pin_out[0], 1);
        wr(8'hE0, 8'h04);
        rd(8'hE1, v); chk("R11", "index 4 read", v, 8'h00);
        wr(8'hE1, 8'hFF);
        chk("R11", "index 4 write ignored", pin_out[0], 1);
        wr(8'hE0, 8'h01);
        rd(8'hE1, v); chk("R11", "bank1 latch unchanged", v, 8'h00);
        wr(8'h03, 8'h00);
    endtask

    task automatic t_inactive();
        logic [7:0] v;
        chk("R3", "oe while active", pin_oe, 22'h000101);
        wr(8'h30, 8'h00);
        chk("R3", "oe when inactive", pin_oe, 0);
        wr(8'h30, 8'hFE);
        rd(8'h30, v); chk("R3", "act bit only", v, 8'h00);
        chk("R3", "oe still off", pin_oe, 0);
        wr(8'h30, 8'h01);
        rd(8'h30, v); chk("R3", "act set", v, 8'h01);
    endtask

    task automatic t_rdata();
        logic [7:0] v;
        rd(8'hF5, v); chk("R12", "fn pin30 read", v, 8'h01);
        rd(8'h50, v); chk("R12", "unmapped read", v, 8'h00);
        rd(8'hE0, v); chk("R12", "fn pin10 read", v, 8'h02);
        repeat (3) @(negedge clk);
        chk("R12", "rdata held", cfg_rdata, 8'h02);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_func();
        t_ctl();
        t_outputs();
        t_special();
        t_pairs();
        t_overlay();
        t_bad_index();
        t_inactive();
        t_rdata();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

endmodule